// File: doc/BRIEF.md
# Lockable Two-Stage APB Watchdog

This block is a down-counting watchdog timer that sits on an APB slave port. A separate clock-enable input sets the rate at which it counts. When the count runs out for the first time, the block flags an interrupt. If software has not serviced that interrupt before the count runs out a second time, the block raises a reset request and stops counting. Software services the watchdog by writing to a clear register. That write drops the interrupt and restarts the count from the programmed reload value.

A key register protects the configuration. Writing one specific 32-bit key opens the block, and writing any other value closes it. While the block is closed, every other write is dropped. A test mode lets software drive both output pins directly, so the wiring can be checked without waiting for a timeout. A bank of fixed identification bytes can be read back.

Top module: `wdt_apb`

## Requirements
- R1: Each clock cycle with `wdog_tick` high, while the counter runs, lowers the count by one. Reading word offset 0x004 returns the current count.
- R2: Bit 0 of the control register (offset 0x008) enables the interrupt output, and bit 1 enables the reset output. All other written bits are dropped and read back as 0.
- R3: A write to offset 0x000 stores the reload value, loads the counter with it at once, and makes the counter run. A read of 0x000 returns the reload value.
- R4: An expiry while the raw interrupt is clear sets the raw interrupt. An expiry while the raw interrupt is already set sets the reset status and stops the counter.
- R5: `wdog_int` equals raw interrupt AND the interrupt enable. `wdog_res` equals reset status AND the reset enable. Offset 0x010 reads the raw interrupt in bit 0, and offset 0x014 reads the masked interrupt in bit 0.
- R6: Any write to offset 0x00C clears the raw interrupt and reloads the counter from the reload value.
- R7: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and writing any other value locks it. A read of 0xC00 returns 1 when locked and 0 when unlocked.
- R8: While the block is locked, writes to any offset other than 0xC00 have no effect.
- R9: When bit 0 of offset 0xF00 is set, `wdog_res` follows bit 0 of offset 0xF04 and `wdog_int` follows bit 1, whatever the status. Offset 0xF00 reads back its bit 0.
- R10: After reset, the control, raw interrupt, reset status, lock, test control and test output registers are all 0. The reload value and the count are 0xFFFFFFFF, and the counter runs.
- R11: An expiry happens on the tick that lowers the count from 1 to 0. The next tick after that reloads the count from the reload value.
- R12: Offsets 0xFD0 through 0xFFC read the bytes 0x04, 0x00, 0x00, 0x00, 0x24, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in rising address order. Offsets 0x00C, 0xF04 and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| wdog_tick | input | 1 | Count enable, one decrement per high cycle |
| wdog_int | output | 1 | Interrupt request |
| wdog_res | output | 1 | Reset request |

## Verification
The bench drives the count right up to the expiry boundary. A design that expires one tick early or late gives the wrong raw status at that boundary. The bench then sends one more tick. A design that skips the reload at zero reads back the wrong count after that tick. The bench also lets the count run out twice without a clear. A design that keeps counting after the reset request, or that needs no earlier interrupt before asserting the reset, reads back the wrong count or drives the wrong pin. While the block is locked, the bench writes the control, load and test registers and reads them back. A leaky lock shows up as a changed value, and so does a key comparison that accepts a value one bit away from the key.

// File: rtl/wdt_pkg.sv
// Package: shared register offsets, key and identification table for the
// watchdog. Assumes 32-bit word accesses. Offsets are word indices (byte
// address bits 11:2).
package wdt_pkg;
    localparam int WIDX_W = 10;

    localparam logic [WIDX_W-1:0] W_LOAD  = 10'h000;
    localparam logic [WIDX_W-1:0] W_COUNT = 10'h001;
    localparam logic [WIDX_W-1:0] W_CTRL  = 10'h002;
    localparam logic [WIDX_W-1:0] W_CLEAR = 10'h003;
    localparam logic [WIDX_W-1:0] W_RAW   = 10'h004;
    localparam logic [WIDX_W-1:0] W_MASK  = 10'h005;
    localparam logic [WIDX_W-1:0] W_KEY   = 10'h300;
    localparam logic [WIDX_W-1:0] W_TCTL  = 10'h3C0;
    localparam logic [WIDX_W-1:0] W_TOUT  = 10'h3C1;
    localparam logic [WIDX_W-1:0] W_ID_LO = 10'h3F4;
    localparam logic [WIDX_W-1:0] W_ID_HI = 10'h3FF;

    localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

    // Identification byte for entry idx (0 = lowest address of the bank).
    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        case (idx)
            4'd0:    id_byte = 8'h04;
            4'd4:    id_byte = 8'h24;
            4'd5:    id_byte = 8'hB8;
            4'd6:    id_byte = 8'h1B;
            4'd8:    id_byte = 8'h0D;
            4'd9:    id_byte = 8'hF0;
            4'd10:   id_byte = 8'h05;
            4'd11:   id_byte = 8'hB1;
            default: id_byte = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/wdt_counter.sv
// Module: watchdog down-counter with reload register.
// Counts down once per tick while running. Signals expiry on the 1->0 step
// and reloads on the tick after zero. A load write or a clear write in the
// same cycle takes priority over the tick. Assumes stop_i is only asserted
// together with expire_o.
module wdt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             ld_we_i,
    input  logic [CNT_W-1:0] ld_val_i,
    input  logic             clr_we_i,
    input  logic             stop_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] load_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, load_q;
    logic             run_q;
    logic             step;

    // Purpose: a tick that is not pre-empted by a register write.
    assign step     = tick_i && run_q && !ld_we_i && !clr_we_i;
    assign expire_o = step && (cnt_q == ONE);
    assign cnt_o    = cnt_q;
    assign load_o   = load_q;

    // Purpose: reload register, count and run flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '1;
            load_q <= '1;
            run_q  <= 1'b1;
        end else if (ld_we_i) begin
            load_q <= ld_val_i;
            cnt_q  <= ld_val_i;
            run_q  <= 1'b1;
        end else if (clr_we_i) begin
            cnt_q <= load_q;
        end else if (step) begin
            cnt_q <= (cnt_q == '0) ? load_q : cnt_q - ONE;
            if (stop_i) run_q <= 1'b0;
        end
    end

    // R1: an unblocked tick on a non-zero count lowers it by one
    a_r1_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);
    // R11: an unblocked tick at zero reloads
    a_r11_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q == '0) |=> cnt_q == $past(load_q));
    // R4: a stopped counter holds unless software writes it
    a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !ld_we_i && !clr_we_i) |=> $stable(cnt_q));
    // R3: a load write lands in both registers
    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we_i |=> (cnt_q == $past(ld_val_i)) && (load_q == $past(ld_val_i)));
endmodule

// File: rtl/wdt_status.sv
// Module: two-stage expiry status and output stage.
// The first expiry sets the raw interrupt. An expiry while that is still set
// sets the sticky reset status and asks the counter to stop. The outputs are
// gated by their enables, or taken from the test register in test mode.
module wdt_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       expire_i,
    input  logic       clr_we_i,
    input  logic       int_en_i,
    input  logic       res_en_i,
    input  logic       test_en_i,
    input  logic [1:0] test_out_i,
    output logic       stop_o,
    output logic       raw_int_o,
    output logic       int_o,
    output logic       res_o
);
    logic raw_q, rst_stat_q;

    assign stop_o    = expire_i && raw_q;
    assign raw_int_o = raw_q;

    // Purpose: raw interrupt and sticky reset status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q      <= 1'b0;
            rst_stat_q <= 1'b0;
        end else begin
            if (clr_we_i)                 raw_q <= 1'b0;
            else if (expire_i && !raw_q)  raw_q <= 1'b1;
            if (expire_i && raw_q)        rst_stat_q <= 1'b1;
        end
    end

    // Purpose: output selection between normal status and test override.
    always_comb begin
        if (test_en_i) begin
            int_o = test_out_i[1];
            res_o = test_out_i[0];
        end else begin
            int_o = raw_q && int_en_i;
            res_o = rst_stat_q && res_en_i;
        end
    end

    // R4: the reset status can only rise if the interrupt was already pending
    a_r4_second_stage: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_stat_q) |-> $past(raw_q));
    // R6: a clear write leaves the raw interrupt low
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> !raw_q);
endmodule

// File: rtl/wdt_regs.sv
// Module: APB register file, lock gate and read mux.
// Writes commit in the access phase. Read data is combinational from the
// address. No wait states and no error response are produced.
module wdt_regs #(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CNT_W-1:0]  load_i,
    input  logic              raw_int_i,
    output logic              ld_we_o,
    output logic              clr_we_o,
    output logic              int_en_o,
    output logic              res_en_o,
    output logic              test_en_o,
    output logic [1:0]        test_out_o
);
    import wdt_pkg::*;

    logic [WIDX_W-1:0] widx;
    logic              wr, wr_ok;
    logic [1:0]        ctrl_q, tout_q;
    logic              lock_q, tctl_q;
    logic [3:0]        id_idx;
    logic              unused_ok;

    assign widx      = paddr[WIDX_W+1:2];
    assign unused_ok = ^paddr[1:0];
    assign wr        = psel && penable && pwrite;
    assign wr_ok     = wr && (!lock_q || widx == W_KEY);
    assign ld_we_o   = wr_ok && widx == W_LOAD;
    assign clr_we_o  = wr_ok && widx == W_CLEAR;
    assign int_en_o  = ctrl_q[0];
    assign res_en_o  = ctrl_q[1];
    assign test_en_o = tctl_q;
    assign test_out_o = tout_q;
    assign id_idx    = 4'(widx - W_ID_LO);

    // Purpose: writable configuration and lock registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            tout_q <= '0;
            tctl_q <= 1'b0;
            lock_q <= 1'b0;
        end else if (wr_ok) begin
            case (widx)
                W_CTRL: ctrl_q <= pwdata[1:0];
                W_TCTL: tctl_q <= pwdata[0];
                W_TOUT: tout_q <= pwdata[1:0];
                W_KEY:  lock_q <= (pwdata[31:0] != UNLOCK_KEY);
                default: ;
            endcase
        end
    end

    // Purpose: read data selection by word offset.
    always_comb begin
        prdata = '0;
        if (widx >= W_ID_LO && widx <= W_ID_HI) begin
            prdata = DATA_W'(id_byte(id_idx));
        end else begin
            case (widx)
                W_LOAD:  prdata = DATA_W'(load_i);
                W_COUNT: prdata = DATA_W'(cnt_i);
                W_CTRL:  prdata = DATA_W'(ctrl_q);
                W_RAW:   prdata = DATA_W'(raw_int_i);
                W_MASK:  prdata = DATA_W'(raw_int_i && ctrl_q[0]);
                W_KEY:   prdata = DATA_W'(lock_q);
                W_TCTL:  prdata = DATA_W'(tctl_q);
                default: prdata = '0;
            endcase
        end
    end

    // R8: while locked, writes elsewhere leave configuration unchanged
    a_r8_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && wr && widx != W_KEY) |=>
            $stable(ctrl_q) && $stable(tctl_q) && $stable(tout_q));
    // R7: the exact key always opens the block
    a_r7_key: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && widx == W_KEY && pwdata[31:0] == UNLOCK_KEY) |=> !lock_q);
endmodule

// File: rtl/wdt_apb.sv
// Module: top of the lockable two-stage APB watchdog.
// Joins the register file, the down-counter and the status/output stage.
// Assumes a single clock: the tick input is already synchronous to clk.
module wdt_apb #(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              wdog_tick,
    output logic              wdog_int,
    output logic              wdog_res
);
    logic [CNT_W-1:0] cnt, load;
    logic ld_we, clr_we, int_en, res_en, test_en, expire, stop, raw_int;
    logic [1:0] test_out;

    wdt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .cnt_i(cnt), .load_i(load), .raw_int_i(raw_int),
        .ld_we_o(ld_we), .clr_we_o(clr_we), .int_en_o(int_en),
        .res_en_o(res_en), .test_en_o(test_en), .test_out_o(test_out)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(wdog_tick), .ld_we_i(ld_we),
        .ld_val_i(pwdata[CNT_W-1:0]), .clr_we_i(clr_we), .stop_i(stop),
        .cnt_o(cnt), .load_o(load), .expire_o(expire)
    );

    wdt_status u_stat (
        .clk(clk), .rst_n(rst_n), .expire_i(expire), .clr_we_i(clr_we),
        .int_en_i(int_en), .res_en_i(res_en), .test_en_i(test_en),
        .test_out_i(test_out), .stop_o(stop), .raw_int_o(raw_int),
        .int_o(wdog_int), .res_o(wdog_res)
    );

    // R5: outside test mode the interrupt pin needs its enable
    a_r5_int_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_en && !int_en) |-> !wdog_int);
endmodule

// File: tb/tb_wdt_apb.sv
// Bench: scoreboard for wdt_apb. Read tasks queue expected data, and a
// negedge monitor compares it when the access phase is seen.
module tb_wdt_apb;
    logic clk = 1'b0, rst_n = 1'b0;
    logic psel = 0, penable = 0, pwrite = 0, wdog_tick = 0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0, prdata;
    logic wdog_int, wdog_res;

    int vectors = 0, fails = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    wdt_apb dut (.clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .wdog_tick(wdog_tick), .wdog_int(wdog_int), .wdog_res(wdog_res));

    // Monitor: compare read data in the access phase.
    always @(negedge clk) begin
        if (psel && penable && !pwrite && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            vectors++;
            if (prdata !== e) begin
                fails++;
                $display("FAIL %s: read 0x%03h got 0x%08h expected 0x%08h", t, paddr, prdata, e);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk); #1 rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); #1 psel = 1; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); #1 penable = 1;
        @(negedge clk); #1 psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); #1 psel = 1; pwrite = 0; paddr = a;
        @(negedge clk); #1 penable = 1;
        @(negedge clk); #1 psel = 0; penable = 0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); #1 wdog_tick = 1;
        repeat (n) @(posedge clk);
        #1 wdog_tick = 0;
    endtask

    task automatic pins(input logic ei, input logic er, input string t);
        vectors++;
        if (wdog_int !== ei || wdog_res !== er) begin
            fails++;
            $display("FAIL %s: pins int/res got %b%b expected %b%b", t, wdog_int, wdog_res, ei, er);
        end
    endtask

    initial begin
        #(5 * 100000);
        fails++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R10 reset state
        rd(12'h000, 32'hFFFF_FFFF, "R10 load");
        rd(12'h004, 32'hFFFF_FFFF, "R10 count");
        rd(12'h008, 0, "R10 ctrl");
        rd(12'h010, 0, "R10 raw");
        rd(12'hC00, 0, "R10 lock");
        rd(12'hF00, 0, "R10 tctl");
        pins(0, 0, "R10 pins");
        // R1 counting from reset
        ticks(3);
        rd(12'h004, 32'hFFFF_FFFC, "R1 count");
        // R2 control field
        wr(12'h008, 32'hFFFF_FFFF);
        rd(12'h008, 3, "R2 ctrl");
        // R3 load
        wr(12'h000, 5);
        rd(12'h004, 5, "R3 count");
        rd(12'h000, 5, "R3 load");
        // R11 / R4 first expiry boundary
        ticks(4);
        rd(12'h010, 0, "R11 before expiry");
        rd(12'h004, 1, "R1 count 1");
        ticks(1);
        rd(12'h010, 1, "R4 raw set");
        rd(12'h014, 1, "R5 masked");
        pins(1, 0, "R5 int pin");
        ticks(1);
        rd(12'h004, 5, "R11 reload");
        // R6 clear
        ticks(2);
        wr(12'h00C, 32'h0);
        rd(12'h010, 0, "R6 raw cleared");
        rd(12'h004, 5, "R6 reloaded");
        pins(0, 0, "R6 pins");
        // R4 second expiry with reset enable off
        wr(12'h008, 1);
        ticks(5);
        pins(1, 0, "R4 first");
        ticks(6);
        pins(1, 0, "R5 res masked");
        wr(12'h008, 3);
        pins(1, 1, "R5 res pin");
        ticks(3);
        rd(12'h004, 0, "R4 stopped");
        rd(12'h014, 1, "R5 masked 2");
        // R7 / R8 lock
        do_reset();
        wr(12'h008, 1);
        wr(12'hC00, 32'h1ACC_E550);
        rd(12'hC00, 1, "R7 locked");
        wr(12'h008, 2);
        rd(12'h008, 1, "R8 ctrl held");
        wr(12'h000, 9);
        rd(12'h004, 32'hFFFF_FFFF, "R8 load ignored");
        wr(12'hF00, 1);
        rd(12'hF00, 0, "R8 tctl held");
        wr(12'hC00, 32'h1ACC_E551);
        rd(12'hC00, 0, "R7 unlocked");
        wr(12'h008, 2);
        rd(12'h008, 2, "R7 ctrl writable");
        // R9 test override
        wr(12'hF04, 2);
        wr(12'hF00, 1);
        pins(1, 0, "R9 int from test");
        rd(12'hF00, 1, "R9 tctl read");
        wr(12'hF04, 1);
        pins(0, 1, "R9 res from test");
        wr(12'hF00, 0);
        pins(0, 0, "R9 normal");
        // R12 identification and write-only reads
        rd(12'hFD0, 32'h04, "R12 id0");
        rd(12'hFE0, 32'h24, "R12 id4");
        rd(12'hFE4, 32'hB8, "R12 id5");
        rd(12'hFF0, 32'h0D, "R12 id8");
        rd(12'hFFC, 32'hB1, "R12 id11");
        rd(12'hF04, 0, "R12 tout wo");
        rd(12'h00C, 0, "R12 clear wo");
        rd(12'h020, 0, "R12 unmapped");
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule